// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is the digital control and serial output stage of a 10-bit successive-approximation converter. A single active-low start line, sampled on the rising clock edge, launches a conversion that always lasts 14 clocks. The first two clocks are set aside for calibration and tracking. Clock 3 carries the sample strobe for the track-and-hold. The result then leaves one bit per clock on a serial line, most significant bit first, updated on falling clock edges.

The converted value arrives on a parallel port that stands in for the comparator path. The block captures it on the falling edge of clock 3, so the port may change after that without affecting the bits being sent. The serial line has a separate enable output that a pad or an external tri-state buffer uses. Three ways of driving the start line give three operating styles. A short pulse gives one conversion and the line then floats. Taking the line low again after a conversion ends starts the next one on the following rising edge, after any number of idle clocks. Holding the line low gives back-to-back conversions with the line driven low between them.

Top module: `adc_conv_seq`

## Requirements
- R1: A conversion lasts exactly 14 clocks, numbered 1 to 14. While start_n stays low, the sample strobes of consecutive conversions are exactly 14 clocks apart.
- R2: In idle, a low start_n at a rising edge makes that edge the start of clock 1, and busy is high from clock 1 through clock 14. Raising start_n during a conversion does not abort it.
- R3: sample_strobe is high for the whole of clock 3 and for no other clock. The value on conv_value is captured on the falling edge of clock 3, and later changes on conv_value have no effect on the bits sent.
- R4: From the falling edge of clock 1 until the first data bit, the serial output is driven low: dout_en = 1 and dout = 0.
- R5: Result bit k (conv_value[k], straight binary, bit 9 first) appears on dout with dout_en = 1 from the falling edge of clock 4 + (9 - k). The LSB appears from the falling edge of clock 13 until the falling edge of clock 14.
- R6: If start_n is high at the falling edge of clock 14, dout_en goes to 0 at that edge and stays 0 while the block is idle.
- R7: If start_n is low at the end of clock 14, the next clock is clock 1 of a new conversion, and dout_en stays 1 with dout = 0 between the two conversions.
- R8: start_n taken low at any time after the falling edge of clock 14, with zero or more idle clocks, starts a conversion on the next rising edge.
- R9: A synchronous active-high reset leaves the block idle with busy = 0, sample_strobe = 0, dout_en = 0 and dout = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| start_n | input | 1 | Start request, active low |
| conv_value | input | 10 | Parallel result from the comparator path |
| sample_strobe | output | 1 | High during clock 3: track-and-hold sample |
| busy | output | 1 | High during clocks 1 to 14 |
| dout | output | 1 | Serial result, MSB first |
| dout_en | output | 1 | Output enable for the serial line; 0 means float |

## Verification
The hardest case to reach from the ports is start_n returning low in the half clock between the falling edge of clock 14 and the next rising edge. In that case the line must float for half a clock and a new conversion must still begin with no idle clock. The bench drives start_n two time units after that falling edge, once with zero idle clocks and once with a gap of several clocks. It also changes conv_value right after the sample clock in every conversion, so a design that does not hold the captured value sends the wrong word.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    DRV_FLOAT = 2'd0,
    DRV_LOW   = 2'd1,
    DRV_DATA  = 2'd2
  } drive_e;

  // Line drive wanted during a given clock of the cycle
  function automatic drive_e pick_drive(input int ph, input logic start_n,
                                        input int first_bit, input int last_bit,
                                        input int cyc);
    if (ph == 0)
      return DRV_FLOAT;
    else if (ph < first_bit)
      return DRV_LOW;
    else if (ph <= last_bit)
      return DRV_DATA;
    else if (ph == cyc)
      return start_n ? DRV_FLOAT : DRV_LOW;
    else
      return DRV_FLOAT;
  endfunction

endpackage

// File: rtl/adc_seq_phase.sv
module adc_seq_phase #(
  parameter int CYC  = 14,
  parameter int SAMP = 3,
  parameter int PW   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_n,
  output logic [PW-1:0] phase,
  output logic          busy,
  output logic          strobe
);

  logic [PW-1:0] nxt;

  always_comb begin
    if (phase == '0 || phase == PW'(CYC))
      nxt = start_n ? '0 : PW'(1);
    else
      nxt = phase + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= '0;
      busy   <= 1'b0;
      strobe <= 1'b0;
    end else begin
      phase  <= nxt;
      busy   <= (nxt != '0);
      strobe <= (nxt == PW'(SAMP));
    end
  end

endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
  parameter int W    = 10,
  parameter int SAMP = 3,
  parameter int PW   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] phase,
  input  logic [W-1:0]  conv_value,
  output logic [W-1:0]  held
);

  // Hold register loaded on the falling edge of the sample clock
  always_ff @(negedge clk) begin
    if (rst)
      held <= '0;
    else if (phase == PW'(SAMP))
      held <= conv_value;
  end

endmodule

// File: rtl/adc_seq_serout.sv
module adc_seq_serout
  import adc_seq_pkg::*;
#(
  parameter int W        = 10,
  parameter int FIRST    = 4,
  parameter int LAST_BIT = 13,
  parameter int CYC      = 14,
  parameter int PW       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_n,
  input  logic [PW-1:0] phase,
  input  logic [W-1:0]  held,
  output logic          dout,
  output logic          dout_en
);

  localparam int IW = (W > 1) ? $clog2(W) : 1;

  drive_e        kind;
  logic [IW-1:0] sel;

  always_comb begin
    kind = pick_drive(int'(phase), start_n, FIRST, LAST_BIT, CYC);
    if (kind == DRV_DATA)
      sel = IW'(W - 1 - (int'(phase) - FIRST));
    else
      sel = '0;
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      dout    <= 1'b0;
      dout_en <= 1'b0;
    end else begin
      dout_en <= (kind != DRV_FLOAT);
      dout    <= (kind == DRV_DATA) ? held[sel] : 1'b0;
    end
  end

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int RES_BITS = 10,
  parameter int CAL_CLKS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_n,
  input  logic [RES_BITS-1:0] conv_value,
  output logic                sample_strobe,
  output logic                busy,
  output logic                dout,
  output logic                dout_en
);

  localparam int SAMP     = CAL_CLKS + 1;
  localparam int FIRST    = SAMP + 1;
  localparam int LAST_BIT = SAMP + RES_BITS;
  localparam int CYC      = LAST_BIT + 1;
  localparam int PW       = $clog2(CYC + 1);

  logic [PW-1:0]       phase;
  logic [RES_BITS-1:0] held;

  adc_seq_phase #(.CYC(CYC), .SAMP(SAMP), .PW(PW)) u_phase (
    .clk(clk), .rst(rst), .start_n(start_n),
    .phase(phase), .busy(busy), .strobe(sample_strobe)
  );

  adc_seq_capture #(.W(RES_BITS), .SAMP(SAMP), .PW(PW)) u_cap (
    .clk(clk), .rst(rst), .phase(phase),
    .conv_value(conv_value), .held(held)
  );

  adc_seq_serout #(.W(RES_BITS), .FIRST(FIRST), .LAST_BIT(LAST_BIT),
                   .CYC(CYC), .PW(PW)) u_out (
    .clk(clk), .rst(rst), .start_n(start_n), .phase(phase),
    .held(held), .dout(dout), .dout_en(dout_en)
  );

endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int RES_BITS = 10,
  parameter int CAL_CLKS = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       start_n,
  input logic [3:0] phase,
  input logic       busy,
  input logic       sample_strobe,
  input logic       dout,
  input logic       dout_en
);

  localparam int SAMP     = CAL_CLKS + 1;
  localparam int FIRST    = SAMP + 1;
  localparam int LAST_BIT = SAMP + RES_BITS;
  localparam int CYC      = LAST_BIT + 1;

  // R1: clocks inside a conversion advance one at a time
  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    (phase != 4'd0 && phase != 4'(CYC)) |=> (phase == $past(phase) + 4'd1));

  // R2: a low start in idle opens clock 1
  p_go_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == 4'd0 && !start_n) |=> (phase == 4'd1 && busy));

  // R3: the sample strobe lasts exactly one clock, inside a conversion
  p_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    sample_strobe |=> !sample_strobe);

  p_strobe_busy_r3: assert property (@(posedge clk) disable iff (rst)
    sample_strobe |-> busy);

  // R4: driven low before data
  p_low_r4: assert property (@(posedge clk) disable iff (rst)
    (phase >= 4'd1 && phase < 4'(FIRST)) |-> (dout_en && !dout));

  // R5: line driven through the data clocks
  p_data_r5: assert property (@(posedge clk) disable iff (rst)
    (phase >= 4'(FIRST) && phase <= 4'(LAST_BIT)) |-> dout_en);

  // R6: floating in idle
  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (phase == 4'd0) |-> !dout_en);

  // R7: back-to-back conversions
  p_free_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == 4'(CYC) && !start_n) |=> (phase == 4'd1));

endmodule

bind adc_conv_seq adc_conv_seq_chk u_chk (
  .clk(clk), .rst(rst), .start_n(start_n), .phase(phase), .busy(busy),
  .sample_strobe(sample_strobe), .dout(dout), .dout_en(dout_en)
);

// File: tb/adc_conv_seq_tb.sv
module adc_conv_seq_tb;

  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_n = 1'b1;
  logic [W-1:0] conv_value = '0;
  logic         sample_strobe, busy, dout, dout_en;

  adc_conv_seq u_dut (
    .clk(clk), .rst(rst), .start_n(start_n), .conv_value(conv_value),
    .sample_strobe(sample_strobe), .busy(busy), .dout(dout), .dout_en(dout_en)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [W-1:0] expq[$];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: pops an expected word at each sample strobe and assembles the serial bits
  int cyc = 0;
  int last_strobe = -1;
  int last_gap = 0;
  int bidx = -1;
  logic prev_strobe = 1'b0;
  logic [W-1:0] exp_word = '0;
  logic [W-1:0] got = '0;

  always @(negedge clk) begin
    #2;
    cyc++;
    if (rst) begin
      prev_strobe = 1'b0;
      bidx = -1;
    end else begin
      if (bidx >= 0) begin
        if (dout_en !== 1'b1) check(1'b0, "R5 enable during data bit", int'(dout_en), 1);
        got[bidx] = dout;
        if (bidx == 0) begin
          check(got == exp_word, "R5 serial word MSB first", int'(got), int'(exp_word));
          bidx = -1;
        end else begin
          bidx--;
        end
      end
      if (sample_strobe && !prev_strobe) begin
        if (last_strobe >= 0) last_gap = cyc - last_strobe;
        last_strobe = cyc;
        if (expq.size() == 0) begin
          check(1'b0, "R3 strobe without conversion", 1, 0);
        end else begin
          exp_word = expq.pop_front();
          bidx = W - 1;
        end
      end
      prev_strobe = sample_strobe;
    end
  end

  // Driver: n conversions; call aligned just after a rising edge or at clock 14 low phase.
  // Ends 2 time units after the falling edge of clock 14 of the last conversion.
  task automatic conv_burst(input int n, input logic [W-1:0] base, input bit early_release);
    start_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] v;
      @(posedge clk);
      #1;
      v = base + W'(i * 203);
      conv_value = v;
      expq.push_back(v);
      check(busy == 1'b1, "R2 busy in clock 1", int'(busy), 1);
      if (early_release) start_n = 1'b1;
      @(negedge clk); #2;
      check(dout_en == 1'b1 && dout == 1'b0, "R4 low in clock 1", int'({dout_en, dout}), 2);
      @(posedge clk);
      @(negedge clk); #2;
      check(sample_strobe == 1'b0, "R3 no strobe in clock 2", int'(sample_strobe), 0);
      @(posedge clk);
      @(negedge clk); #2;
      check(sample_strobe == 1'b1, "R3 strobe in clock 3", int'(sample_strobe), 1);
      check(dout_en == 1'b1 && dout == 1'b0, "R4 low in clock 3", int'({dout_en, dout}), 2);
      @(posedge clk);
      #1;
      conv_value = ~v;
      repeat (10) @(posedge clk);
      #1;
      if (i == n - 1) start_n = 1'b1;
      @(negedge clk); #2;
      if (i == n - 1)
        check(dout_en == 1'b0, "R6 float after last clock 14", int'(dout_en), 0);
      else
        check(dout_en == 1'b1 && dout == 1'b0, "R7 low between free-run cycles",
              int'({dout_en, dout}), 2);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(busy == 1'b0, "R9 busy in reset", int'(busy), 0);
    check(sample_strobe == 1'b0, "R9 strobe in reset", int'(sample_strobe), 0);
    check(dout_en == 1'b0, "R9 enable in reset", int'(dout_en), 0);
    check(dout == 1'b0, "R9 dout in reset", int'(dout), 0);
    rst = 1'b0;

    repeat (5) @(posedge clk);
    #1;
    check(busy == 1'b0, "R2 stays idle with start high", int'(busy), 0);
    check(dout_en == 1'b0, "R6 float while idle", int'(dout_en), 0);

    // single shot
    conv_burst(1, 10'h2A5, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    check(dout_en == 1'b0 && busy == 1'b0, "R6 idle and floating after single shot",
          int'({dout_en, busy}), 0);
    @(posedge clk); #1;

    // start released right after clock 1: conversion still completes
    conv_burst(1, 10'h3FF, 1'b1);
    @(posedge clk); #1;

    // all zeros then zero-gap synchronized restart
    conv_burst(1, 10'h000, 1'b0);
    conv_burst(1, 10'h155, 1'b0);   // R8: start low within half clock after clock 14

    // synchronized with four idle clocks
    repeat (4) @(posedge clk);
    #1;
    check(busy == 1'b0, "R8 idle gap", int'(busy), 0);
    conv_burst(1, 10'h001, 1'b0);   // R8
    @(posedge clk); #1;

    // free run, three conversions back to back
    conv_burst(3, 10'h200, 1'b0);
    check(last_gap == 14, "R1 strobe spacing in free run", last_gap, 14);

    repeat (4) @(posedge clk);
    #1;
    check(expq.size() == 0, "R5 all words observed", expq.size(), 0);
    check(busy == 1'b0, "R1 idle after last conversion", int'(busy), 0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(1'b0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule